// File: doc/BRIEF.md
# Paged display memory host port

This block sits between a host command bus and a dual-port display memory of 65 rows by 200 columns. The rows form eight full pages of eight rows each and a ninth page that holds a single indicator row. The host selects a page and a column with two address commands, then streams data bytes in or out. Each byte covers eight rows of one column: bit 0 is the top row of the page and bit 7 is the bottom row. After every data byte the column steps forward by one, so a run of bytes fills a horizontal strip of the page.

The column counter stops at the last column and never carries into the page. Moving to another page always takes a new page command. A second, read-only port lets a display scanner fetch any byte by page and column at the same time as host traffic. On the indicator page only bit 0 is stored, and the other bits read as zero on both ports.

Top module: `pgram_host_port`

## Requirements
- R1: Reset sets the page and the column to 0, so the first data byte after reset lands at page 0, column 0, and `rd_valid` is low.
- R2: A page command (`cmd_op`=0) with a value from 0 to 8 selects that page. The page then stays the same through any number of column and data commands.
- R3: A page command with a value above 8 is ignored, and the page selected before it stays in force.
- R4: A column command (`cmd_op`=1) loads the column. A value above 199 (0xC7) loads 199.
- R5: Each data write (`cmd_op`=2) or data read (`cmd_op`=3) uses the current address and then moves the column up by one.
- R6: At column 199 a data access leaves the column at 199, so a further access reuses it. The page never changes because of a data access.
- R7: On page 8 a write stores only `cmd_data` bit 0, and a read returns 0 in bits 7..1.
- R8: A data read sets `rd_valid` high on the next cycle, with `rd_data` holding the byte at the address used. In every other cycle `rd_valid` is low.
- R9: The scanner port returns, one cycle after `scan_page`/`scan_col` are presented, the byte stored at that page and column, with bit k as row 8*page+k. A page above 8 or a column above 199 returns 0. Host writes to other addresses in the same cycle do not disturb the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 0 page set, 1 column set, 2 data write, 3 data read |
| cmd_data | input | 8 | Address value or write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read command |
| rd_data | output | 8 | Byte returned by a host read |
| scan_page | input | 4 | Scanner page address |
| scan_col | input | 8 | Scanner column address |
| scan_data | output | 8 | Scanner byte, one cycle after the address |

## Verification
A wrong page or column register shows up as misplaced data. The first write after the fault lands at the wrong address, and the mismatch appears as soon as the scanner or a host read visits that location. This can be as early as the next cycle. A counter that wraps or carries instead of saturating overwrites column 0 or the next page, and a check of those locations after a run past column 199 exposes it. Missing bit masking on the indicator page shows on the very next read of that page as nonzero upper bits.

// File: rtl/pgram_pkg.sv
package pgram_pkg;
  typedef enum logic [1:0] {
    OP_PAGE = 2'd0,
    OP_COL  = 2'd1,
    OP_WR   = 2'd2,
    OP_RD   = 2'd3
  } host_op_e;
endpackage

// File: rtl/pgram_addr_ctl.sv
module pgram_addr_ctl #(
  parameter int PAGES_FULL = 8,
  parameter int COLS       = 200,
  parameter int DW         = 8,
  parameter int PG_W       = 4,
  parameter int COL_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  pgram_pkg::host_op_e  cmd_op,
  input  logic [DW-1:0]        cmd_data,
  output logic [PG_W-1:0]      page_q,
  output logic [COL_W-1:0]     col_q,
  output logic                 data_acc
);
  import pgram_pkg::*;

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  int unsigned       arg;
  logic              page_ok;
  logic [COL_W-1:0]  col_load;

  always_comb begin
    arg      = int'(cmd_data);
    page_ok  = (arg <= PAGES_FULL);
    col_load = (arg > COLS - 1) ? LAST_COL : COL_W'(arg);
    data_acc = cmd_valid && (cmd_op == OP_WR || cmd_op == OP_RD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      col_q  <= '0;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_PAGE: if (page_ok) page_q <= PG_W'(arg);
        OP_COL:  col_q <= col_load;
        default: if (col_q != LAST_COL) col_q <= col_q + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pgram_dpram.sv
module pgram_dpram #(
  parameter int DW    = 8,
  parameter int DEPTH = 1800,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/pgram_host_port.sv
module pgram_host_port #(
  parameter int PAGES_FULL = 8,
  parameter int COLS       = 200,
  parameter int DW         = 8,
  localparam int PAGES     = PAGES_FULL + 1,
  localparam int PG_W      = $clog2(PAGES),
  localparam int COL_W     = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [DW-1:0]    cmd_data,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  input  logic [PG_W-1:0]  scan_page,
  input  logic [COL_W-1:0] scan_col,
  output logic [DW-1:0]    scan_data
);
  import pgram_pkg::*;

  localparam int DEPTH = PAGES * COLS;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [PG_W-1:0]  IND_PAGE = PG_W'(PAGES_FULL);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
  localparam logic [DW-1:0]    IND_MASK = DW'(1);

  function automatic logic [AW-1:0] flat(input logic [PG_W-1:0] p,
                                         input logic [COL_W-1:0] c);
    return AW'(p) * AW'(COLS) + AW'(c);
  endfunction

  host_op_e          op;
  logic [PG_W-1:0]   page_q;
  logic [COL_W-1:0]  col_q;
  logic              data_acc;
  logic              host_we;
  logic [AW-1:0]     host_addr;
  logic [DW-1:0]     host_wdata;
  logic [DW-1:0]     host_q;
  logic              scan_ok;
  logic [AW-1:0]     scan_addr;
  logic [DW-1:0]     scan_q;
  logic              rd_pg8_q;
  logic              scan_ok_q;
  logic              scan_pg8_q;

  assign op = host_op_e'(cmd_op);

  pgram_addr_ctl #(
    .PAGES_FULL(PAGES_FULL), .COLS(COLS), .DW(DW),
    .PG_W(PG_W), .COL_W(COL_W)
  ) u_addr (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(op),
    .cmd_data(cmd_data), .page_q(page_q), .col_q(col_q),
    .data_acc(data_acc)
  );

  always_comb begin
    host_we    = data_acc && (op == OP_WR);
    host_addr  = flat(page_q, col_q);
    host_wdata = (page_q == IND_PAGE) ? (cmd_data & IND_MASK) : cmd_data;
    scan_ok    = (scan_page <= IND_PAGE) && (scan_col <= LAST_COL);
    scan_addr  = scan_ok ? flat(scan_page, scan_col) : '0;
  end

  pgram_dpram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .a_we(host_we), .a_addr(host_addr), .a_wdata(host_wdata),
    .a_rdata(host_q), .b_addr(scan_addr), .b_rdata(scan_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_pg8_q   <= 1'b0;
      scan_ok_q  <= 1'b0;
      scan_pg8_q <= 1'b0;
    end else begin
      rd_valid   <= data_acc && (op == OP_RD);
      rd_pg8_q   <= (page_q == IND_PAGE);
      scan_ok_q  <= scan_ok;
      scan_pg8_q <= (scan_page == IND_PAGE);
    end
  end

  always_comb begin
    rd_data   = rd_pg8_q ? (host_q & IND_MASK) : host_q;
    scan_data = !scan_ok_q ? '0 : (scan_pg8_q ? (scan_q & IND_MASK) : scan_q);
  end
endmodule

// File: rtl/pgram_host_port_chk.sv
module pgram_host_port_chk #(
  parameter int PAGES_FULL = 8,
  parameter int COLS       = 200,
  parameter int DW         = 8,
  parameter int PG_W       = 4,
  parameter int COL_W      = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [DW-1:0]    cmd_data,
  input logic [PG_W-1:0]  page_q,
  input logic [COL_W-1:0] col_q,
  input logic             rd_valid,
  input logic [DW-1:0]    rd_data
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic is_page, is_col, is_data, is_rd;
  assign is_page = cmd_valid && cmd_op == 2'd0;
  assign is_col  = cmd_valid && cmd_op == 2'd1;
  assign is_data = cmd_valid && cmd_op[1];
  assign is_rd   = cmd_valid && cmd_op == 2'd3;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (page_q == '0 && col_q == '0));

  a_r2_page_hold: assert property (@(posedge clk) disable iff (rst)
    !is_page |=> $stable(page_q));

  a_r3_page_ignore: assert property (@(posedge clk) disable iff (rst)
    (is_page && int'(cmd_data) > PAGES_FULL) |=> $stable(page_q));

  a_r4_col_clamp: assert property (@(posedge clk) disable iff (rst)
    (is_col && int'(cmd_data) > COLS - 1) |=> col_q == LAST_COL);

  a_r5_col_step: assert property (@(posedge clk) disable iff (rst)
    (is_data && col_q != LAST_COL) |=> col_q == COL_W'($past(col_q) + 1'b1));

  a_r6_col_sat: assert property (@(posedge clk) disable iff (rst)
    (is_data && col_q == LAST_COL) |=> col_q == LAST_COL);

  a_r7_ind_bits: assert property (@(posedge clk) disable iff (rst)
    (is_rd && int'(page_q) == PAGES_FULL) |=> rd_data[DW-1:1] == '0);

  a_r8_rd_valid: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> rd_valid);

  a_r8_rd_quiet: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> !rd_valid);
endmodule

bind pgram_host_port pgram_host_port_chk #(
  .PAGES_FULL(PAGES_FULL), .COLS(COLS), .DW(DW), .PG_W(PG_W), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_data(cmd_data), .page_q(page_q), .col_q(col_q),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/sim_pgram_host_port.sv
module sim_pgram_host_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [3:0] scan_page = 4'd0;
  logic [7:0] scan_col = 8'd0;
  logic [7:0] scan_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] bm [9][200];
  int mp = 0;
  int mc = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  pgram_host_port u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .scan_page(scan_page), .scan_col(scan_col), .scan_data(scan_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic issue(input int op, input int d, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op[1:0];
    cmd_data  = d[7:0];
    case (op)
      0: if (d <= 8) mp = d;
      1: mc = (d > 199) ? 199 : d;
      2: begin
        bm[mp][mc] = (mp == 8) ? (d[7:0] & 8'h01) : d[7:0];
        if (mc < 199) mc++;
      end
      default: begin
        exp_q.push_back(bm[mp][mc]);
        tag_q.push_back(tag);
        if (mc < 199) mc++;
      end
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  task automatic scan_chk(input int p, input int c, input string tag);
    @(negedge clk);
    cmd_valid = 1'b0;
    scan_page = p[3:0];
    scan_col  = c[7:0];
    @(negedge clk);
    chk(tag, scan_data, (p > 8 || c > 199) ? 8'h00 : bm[p][c]);
  endtask

  // scoreboard monitor for host reads
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R8 unexpected rd_valid actual=%02h expected=none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rd_data, e);
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_valid after reset", {7'b0, rd_valid}, 8'h00);

    // R1 / R5: first writes go to page 0 from column 0
    issue(2, 8'hA5, "R1");
    issue(2, 8'h3C, "R5");
    scan_chk(0, 0, "R1 first byte at page 0 col 0");
    scan_chk(0, 1, "R5 second byte at col 1");

    // R2 / R5 / R8: page 3 strip, read back
    issue(0, 3, "R2");
    issue(1, 10, "R4");
    issue(2, 8'h11, "R5");
    issue(2, 8'h22, "R5");
    issue(2, 8'h33, "R5");
    issue(1, 10, "R4");
    issue(3, 0, "R8 read page 3 col 10");
    issue(3, 0, "R5 read page 3 col 11");
    issue(3, 0, "R2 read page 3 col 12");
    idle(2);

    // prepare page 4 col 0 for no-carry check
    issue(0, 4, "R2");
    issue(1, 0, "R4");
    issue(2, 8'h5A, "R2");

    // R3: out-of-range page values ignored
    issue(0, 3, "R2");
    issue(0, 9, "R3");
    issue(0, 8'hF0, "R3");
    issue(1, 0, "R4");
    issue(2, 8'h77, "R3");
    scan_chk(3, 0, "R3 write stayed on page 3");

    // R4 / R6: clamp and saturation
    issue(1, 250, "R4");
    issue(2, 8'h99, "R4");
    issue(2, 8'h88, "R6");
    issue(1, 255, "R4");
    issue(3, 0, "R6 read col 199");
    issue(3, 0, "R6 read col 199 again");
    idle(2);
    scan_chk(3, 199, "R6 last column holds latest byte");
    scan_chk(3, 0, "R6 no wrap to col 0");
    scan_chk(4, 0, "R6 no carry into page 4");

    // R7: indicator page
    issue(0, 8, "R7");
    issue(1, 5, "R7");
    issue(2, 8'hFF, "R7");
    issue(2, 8'hFE, "R7");
    issue(1, 5, "R7");
    issue(3, 0, "R7 read indicator bit set");
    issue(3, 0, "R7 read indicator bit clear");
    idle(2);
    scan_chk(8, 5, "R7 scanner indicator byte");
    scan_chk(8, 6, "R7 scanner indicator zero");

    // R9: scanner out of range and concurrent with host writes
    scan_chk(9, 0, "R9 page out of range");
    scan_chk(0, 220, "R9 column out of range");
    issue(0, 0, "R2");
    issue(1, 50, "R4");
    @(negedge clk);
    scan_page = 4'd3;
    scan_col  = 8'd11;
    cmd_valid = 1'b1;
    cmd_op    = 2'd2;
    cmd_data  = 8'hC3;
    bm[0][50] = 8'hC3;
    mc = 51;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 scan during host write", scan_data, bm[3][11]);
    scan_chk(0, 50, "R9 host write visible to scanner");

    // R5 / R6: full strip on page 7
    issue(0, 7, "R2");
    issue(1, 0, "R4");
    for (int i = 0; i < 200; i++) issue(2, (i * 37 + 11) & 255, "R5");
    issue(1, 0, "R4");
    for (int i = 0; i < 200; i++) issue(3, 0, "R5 page 7 strip readback");
    issue(3, 0, "R6 read beyond end");
    idle(3);
    scan_chk(7, 0, "R9 scanner page 7 col 0");
    scan_chk(7, 123, "R9 scanner page 7 col 123");
    scan_chk(7, 199, "R9 scanner page 7 col 199");

    chk("R8 all reads answered", 8'(exp_q.size()), 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule